// File: doc/BRIEF.md
# R-Type Integer Instruction Decoder

This block turns one 32-bit integer instruction into a packed control word for the pipeline. The instruction arrives zero-extended in a 64-bit field. The block pulls out the two source register numbers and the destination register number. It classifies the register-register arithmetic, logic, shift and compare operations into a 5-bit ALU operation code. It also raises a register-write enable when it recognises the instruction.

The block covers two encoding groups: the full-width group and the 32-bit word group. Both map into one shared operation space. Anything the block does not recognise comes out as an add with the write enable low. A later stage can therefore let such an instruction flow through without touching the register file.

The block is purely combinational and has no handshake, because it is one step inside a pipeline stage. The stage around it owns valid/ready and back-pressure. The output word always follows the input within the same cycle.

Top module: `rr_decoder`

## Requirements
- R1: The output register fields always copy the instruction: source-1 from bits [19:15], source-2 from bits [24:20], destination from bits [11:7], whether or not the instruction is recognised.
- R2: The 21-bit output word is packed, from MSB to LSB, as {src1[4:0], src2[4:0], op[4:0], wen, dest[4:0]}, so op sits at bits [10:6] and wen at bit 5.
- R3: With opcode bits [6:0] = 0110011 and funct7 bits [31:25] = 0000000, the funct3 value in bits [14:12] selects the operation and wen is 1. The mapping is 000 to ADD (op 00000), 001 to SLL (00010), 010 to SLT (00011), 011 to SLTU (00100), 100 to XOR (00101), 101 to SRL (00110), 110 to OR (01000) and 111 to AND (01001).
- R4: With opcode 0110011 and funct7 0100000, funct3 000 gives SUB (00001) and funct3 101 gives SRA (00111), both with wen 1. Any other funct3, or any funct7 other than 0000000 or 0100000, is unrecognised.
- R5: With opcode 0111011, the word forms decode with wen 1. Under funct7 0000000, funct3 000 gives ADDW (01010), 001 gives SLLW (01100) and 101 gives SRLW (01101). Under funct7 0100000, funct3 000 gives SUBW (01011) and 101 gives SRAW (01110).
- R6: In the word group, funct3 010, 011, 100, 110 and 111 are unrecognised under any funct7, and so is funct3 001 under funct7 0100000.
- R7: An unrecognised instruction, including any other opcode, yields op 00000 and wen 0.
- R8: Bits [63:32] of the instruction field have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 64 | Instruction, 32-bit encoding zero-extended |
| info_o | output | 21 | Packed decode word {src1, src2, op, wen, dest} |

## Verification
The checker evaluates several properties every time the input changes. It confirms that the register fields pass through unchanged and that every unrecognised result carries op zero. It also confirms that a word-group code only appears with the word opcode, that funct7 values outside the two legal patterns never set the write enable, and that the illegal word-group funct3 values are rejected. None of these pins down which code each operation gets, or whether the upper 32 bits are ignored. The bench covers those: it sweeps every encoding from the directed tables, then runs a long pseudo-random stream with junk in the upper half, checking each result against an independent behavioural model.

// File: rtl/rr_decoder_pkg.sv
package rr_decoder_pkg;
  localparam int REG_AW = 5;
  localparam int OP_W   = 5;
  localparam int INFO_W = 2 * REG_AW + OP_W + 1 + REG_AW;

  localparam logic [6:0] OPC_FULL = 7'b0110011;
  localparam logic [6:0] OPC_WORD = 7'b0111011;
  localparam logic [6:0] F7_BASE  = 7'b0000000;
  localparam logic [6:0] F7_ALT   = 7'b0100000;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_SLL  = 5'd2,  OP_SLT  = 5'd3,
    OP_SLTU = 5'd4,  OP_XOR  = 5'd5,  OP_SRL  = 5'd6,  OP_SRA  = 5'd7,
    OP_OR   = 5'd8,  OP_AND  = 5'd9,  OP_ADDW = 5'd10, OP_SUBW = 5'd11,
    OP_SLLW = 5'd12, OP_SRLW = 5'd13, OP_SRAW = 5'd14
  } alu_op_e;

  typedef struct packed {
    logic [REG_AW-1:0] src1;
    logic [REG_AW-1:0] src2;
    alu_op_e           op;
    logic              wen;
    logic [REG_AW-1:0] dest;
  } info_t;
endpackage

// File: rtl/rr_fields.sv
module rr_fields #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] inst,
  output logic [6:0]      opcode,
  output logic [2:0]      funct3,
  output logic [6:0]      funct7,
  output logic [4:0]      rs1,
  output logic [4:0]      rs2,
  output logic [4:0]      rd
);
  logic unused_upper;
  assign unused_upper = ^inst[XLEN-1:32];

  assign opcode = inst[6:0];
  assign rd     = inst[11:7];
  assign funct3 = inst[14:12];
  assign rs1    = inst[19:15];
  assign rs2    = inst[24:20];
  assign funct7 = inst[31:25];
endmodule

// File: rtl/rr_group.sv
module rr_group
  import rr_decoder_pkg::*;
#(
  parameter bit WORD_FORM = 1'b0
) (
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output logic       hit,
  output alu_op_e    op
);
  localparam logic [6:0] MY_OPC = WORD_FORM ? OPC_WORD : OPC_FULL;

  logic opc_ok, base, alt;
  assign opc_ok = (opcode == MY_OPC);
  assign base   = (funct7 == F7_BASE);
  assign alt    = (funct7 == F7_ALT);

  generate
    if (WORD_FORM) begin : g_word
      always_comb begin
        hit = 1'b0;
        op  = OP_ADD;
        if (opc_ok && base) begin
          unique case (funct3)
            3'b000:  begin hit = 1'b1; op = OP_ADDW; end
            3'b001:  begin hit = 1'b1; op = OP_SLLW; end
            3'b101:  begin hit = 1'b1; op = OP_SRLW; end
            default: ;
          endcase
        end else if (opc_ok && alt) begin
          unique case (funct3)
            3'b000:  begin hit = 1'b1; op = OP_SUBW; end
            3'b101:  begin hit = 1'b1; op = OP_SRAW; end
            default: ;
          endcase
        end
      end
    end else begin : g_full
      always_comb begin
        hit = 1'b0;
        op  = OP_ADD;
        if (opc_ok && base) begin
          hit = 1'b1;
          unique case (funct3)
            3'b000: op = OP_ADD;
            3'b001: op = OP_SLL;
            3'b010: op = OP_SLT;
            3'b011: op = OP_SLTU;
            3'b100: op = OP_XOR;
            3'b101: op = OP_SRL;
            3'b110: op = OP_OR;
            3'b111: op = OP_AND;
          endcase
        end else if (opc_ok && alt) begin
          unique case (funct3)
            3'b000:  begin hit = 1'b1; op = OP_SUB; end
            3'b101:  begin hit = 1'b1; op = OP_SRA; end
            default: ;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rr_decoder.sv
module rr_decoder
  import rr_decoder_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   inst_i,
  output logic [INFO_W-1:0] info_o
);
  localparam int N_GROUPS = 2;

  logic [6:0] opcode, funct7;
  logic [2:0] funct3;
  logic [4:0] rs1, rs2, rd;

  rr_fields #(.XLEN(XLEN)) u_fields (
    .inst   (inst_i),
    .opcode (opcode),
    .funct3 (funct3),
    .funct7 (funct7),
    .rs1    (rs1),
    .rs2    (rs2),
    .rd     (rd)
  );

  logic    [N_GROUPS-1:0] grp_hit;
  alu_op_e                grp_op [N_GROUPS];

  generate
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      rr_group #(.WORD_FORM(g == 1)) u_grp (
        .opcode (opcode),
        .funct3 (funct3),
        .funct7 (funct7),
        .hit    (grp_hit[g]),
        .op     (grp_op[g])
      );
    end
  endgenerate

  info_t word;
  always_comb begin
    word.src1 = rs1;
    word.src2 = rs2;
    word.dest = rd;
    word.wen  = |grp_hit;
    word.op   = OP_ADD;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (grp_hit[g]) word.op = grp_op[g];
    end
  end

  assign info_o = word;
endmodule

// File: rtl/rr_decoder_checker.sv
module rr_decoder_checker #(
  parameter int XLEN = 64
) (
  input logic [XLEN-1:0] inst_i,
  input logic [20:0]     info_o
);
  logic [6:0] c_opc, c_f7;
  logic [2:0] c_f3;
  logic [4:0] c_op;
  logic       c_wen;
  assign c_opc = inst_i[6:0];
  assign c_f3  = inst_i[14:12];
  assign c_f7  = inst_i[31:25];
  assign c_op  = info_o[10:6];
  assign c_wen = info_o[5];

  always_comb begin
    if (!$isunknown(inst_i)) begin
      assert_reg_fields_R1: assert (info_o[20:16] == inst_i[19:15] &&
                                    info_o[15:11] == inst_i[24:20] &&
                                    info_o[4:0]   == inst_i[11:7])
        else $error("register fields not passed through");
      assert_op_in_range_R3: assert (!c_wen || c_op <= 5'd14)
        else $error("op code out of range");
      assert_bad_funct7_R4: assert (c_f7 == 7'h00 || c_f7 == 7'h20 || !c_wen)
        else $error("illegal funct7 recognised");
      assert_word_opcode_R5: assert (!(c_wen && c_op >= 5'd10) || c_opc == 7'b0111011)
        else $error("word code without word opcode");
      assert_word_funct3_R6: assert (!(c_opc == 7'b0111011 &&
                                       (c_f3 == 3'b010 || c_f3 == 3'b011 || c_f3 == 3'b100 ||
                                        c_f3 == 3'b110 || c_f3 == 3'b111)) || !c_wen)
        else $error("illegal word funct3 recognised");
      assert_default_add_R7: assert (c_wen || c_op == 5'd0)
        else $error("unrecognised result not an add");
    end
  end
endmodule

bind rr_decoder rr_decoder_checker #(.XLEN(XLEN)) u_checker (
  .inst_i (inst_i),
  .info_o (info_o)
);

// File: tb/rr_decoder_tb.sv
module rr_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic [63:0] inst = 64'd0;
  logic [20:0] info;
  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_decoder u_dut (.inst_i(inst), .info_o(info));

  // Behavioural reference from the requirement text.
  function automatic logic [20:0] model(input logic [63:0] w);
    logic [6:0] opc = w[6:0];
    logic [2:0] f3  = w[14:12];
    logic [6:0] f7  = w[31:25];
    int  code = 0;
    bit  ok   = 0;
    if (opc == 7'h33 && f7 == 7'h00) begin
      ok = 1;
      case (f3)
        3'd0: code = 0;  3'd1: code = 2;  3'd2: code = 3;  3'd3: code = 4;
        3'd4: code = 5;  3'd5: code = 6;  3'd6: code = 8;  default: code = 9;
      endcase
    end else if (opc == 7'h33 && f7 == 7'h20) begin
      if (f3 == 3'd0) begin ok = 1; code = 1; end
      if (f3 == 3'd5) begin ok = 1; code = 7; end
    end else if (opc == 7'h3B && f7 == 7'h00) begin
      if (f3 == 3'd0) begin ok = 1; code = 10; end
      if (f3 == 3'd1) begin ok = 1; code = 12; end
      if (f3 == 3'd5) begin ok = 1; code = 13; end
    end else if (opc == 7'h3B && f7 == 7'h20) begin
      if (f3 == 3'd0) begin ok = 1; code = 11; end
      if (f3 == 3'd5) begin ok = 1; code = 14; end
    end
    if (!ok) code = 0;
    return {w[19:15], w[24:20], code[4:0], ok, w[11:7]};
  endfunction

  function automatic string tag_of(input logic [63:0] w);
    if (w[63:32] != 0) return "R8";
    if (w[6:0] == 7'h33 && w[31:25] == 7'h00) return "R3";
    if (w[6:0] == 7'h33) return "R4";
    if (w[6:0] == 7'h3B && model(w)[5]) return "R5";
    if (w[6:0] == 7'h3B) return "R6";
    return "R7";
  endfunction

  function automatic logic [63:0] mk(input logic [6:0] f7, input logic [4:0] r2,
                                     input logic [4:0] r1, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {32'd0, f7, r2, r1, f3, rd, opc};
  endfunction

  task automatic apply(input logic [63:0] w, input string tag);
    logic [20:0] exp_v;
    @(posedge clk);
    #1 inst = w;
    @(negedge clk);
    exp_v = model(w);
    n_cmp++;
    if (info !== exp_v) begin
      n_bad++;
      $display("FAIL %s inst=%h actual=%h expected=%h", tag, w, info, exp_v);
    end
  endtask

  initial begin
    logic [31:0] lfsr = 32'hACE1_2345;
    // Zero input: all-zero word (R7)
    apply(64'd0, "R7");
    // R1/R2: distinct field values, checked as packed word
    apply(mk(7'h00, 5'd21, 5'd10, 3'd0, 5'd31, 7'h33), "R1");
    apply(mk(7'h00, 5'd1, 5'd31, 3'd7, 5'd0, 7'h33), "R2");
    // R1 on unrecognised opcode: fields still pass through
    apply(mk(7'h00, 5'd7, 5'd19, 3'd0, 5'd12, 7'h13), "R1");
    // R3: all full-width base ops
    for (int f = 0; f < 8; f++) apply(mk(7'h00, 5'd3, 5'd4, f[2:0], 5'd5, 7'h33), "R3");
    // R4: alt funct7 over all funct3 and bad funct7 values
    for (int f = 0; f < 8; f++) apply(mk(7'h20, 5'd9, 5'd8, f[2:0], 5'd2, 7'h33), "R4");
    apply(mk(7'h01, 5'd9, 5'd8, 3'd0, 5'd2, 7'h33), "R4");
    apply(mk(7'h60, 5'd9, 5'd8, 3'd5, 5'd2, 7'h33), "R4");
    // R5/R6: word group over all funct3, both funct7
    for (int f = 0; f < 8; f++) apply(mk(7'h00, 5'd6, 5'd11, f[2:0], 5'd14, 7'h3B), "R5");
    for (int f = 0; f < 8; f++) apply(mk(7'h20, 5'd6, 5'd11, f[2:0], 5'd14, 7'h3B), "R6");
    apply(mk(7'h01, 5'd6, 5'd11, 3'd1, 5'd14, 7'h3B), "R6");
    // R7: other opcodes
    apply(mk(7'h00, 5'd1, 5'd2, 3'd0, 5'd3, 7'h13), "R7");
    apply(mk(7'h20, 5'd1, 5'd2, 3'd5, 5'd3, 7'h1B), "R7");
    apply(mk(7'h00, 5'd1, 5'd2, 3'd0, 5'd3, 7'h37), "R7");
    // R8: upper half junk must not matter
    apply({32'hFFFF_FFFF, 32'h4000_50B3}, "R8");
    apply({32'h8000_0001, 32'h0000_003B}, "R8");
    // Random stream
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [63:0] w;
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr ^ (a * 32'd2654435761);
      w = {(b[3] ? a : 32'd0), a};
      case (b[6:5])
        2'd0: w[6:0] = 7'h33;
        2'd1: w[6:0] = 7'h3B;
        2'd2: w[6:0] = b[0] ? 7'h33 : 7'h3B;
        default: ;
      endcase
      case (b[9:8])
        2'd0: w[31:25] = 7'h00;
        2'd1: w[31:25] = 7'h20;
        2'd2: w[31:25] = b[1] ? 7'h00 : 7'h20;
        default: ;
      endcase
      apply(w, tag_of(w));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule